// File: doc/BRIEF.md
# Pin-Selected Timestamp Capture Unit

This block records a free-running 32-bit counter value at the moment a chosen general-purpose input goes from low to high. The inputs are grouped into four ports of eight pins. A select byte written by software names one port and one pin within it. The chosen pin passes through a synchronizer and then an edge detector. On a rising edge the unit stores the counter value and raises a valid flag.

The capture is one-shot. After the flag is set, the stored value stays frozen and later edges are ignored. Software clears the flag with a single write pulse, and that re-arms the unit. Software reads the stored value one byte at a time through a byte index.

Some select codes name no pin. These are the port codes above three and pin number zero. With such a code the unit never captures. Changing the select also empties the edge detector's history, so a pin that is already high when it is selected does not count as an edge.

Top module: `tscap_unit`

## Requirements
- R1: The select byte written with `sel_wr` is decoded as follows. Bits [5:3] give the port code: 0, 1, 2 and 3 select inputs `gpio_in[7:0]`, `[15:8]`, `[23:16]` and `[31:24]`. Bits [2:0] give the pin within that port. Bits [7:6] are ignored. The new select is used from the cycle after the write.
- R2: While the port code is 4, 5, 6 or 7, no capture occurs, whatever the inputs do.
- R3: While the pin number is 0, no capture occurs.
- R4: A capture happens when the selected pin goes from low to high. The pin is sampled on each clock edge. Counting the first edge at which the pin is sampled high as edge 1, the value of `count_in` present at edge 3 is stored. `capture_valid` reads 1 after edge 3 and 0 after edges 1 and 2.
- R5: A capture sets `capture_valid` to 1. A one-cycle `clr_valid` pulse clears it at the next edge. If a clear and a capture edge fall in the same cycle, the clear wins and nothing is stored.
- R6: While `capture_valid` is 1, further edges are ignored and the stored value does not change.
- R7: `rd_byte` shows a byte of the stored value, chosen by `rd_idx`: index 0 gives bits [7:0], 1 gives [15:8], 2 gives [23:16] and 3 gives [31:24]. The read has no clock delay.
- R8: In the cycle after a select write, no capture can occur. A newly selected pin that is already high is not taken as an edge. It must go low and then high again.
- R9: After reset, `capture_valid` is 0, the stored value is 0, and the select is port 0 with pin 0, which inhibits capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gpio_in | input | 32 | Asynchronous pin inputs, four ports of eight |
| count_in | input | 32 | Counter value to timestamp |
| sel_wr | input | 1 | Write strobe for the select byte |
| sel_wdata | input | 8 | Select byte: port code [5:3], pin [2:0] |
| clr_valid | input | 1 | Pulse that clears the valid flag |
| rd_idx | input | 2 | Byte index into the stored value |
| rd_byte | output | 8 | Selected byte of the stored value |
| capture_valid | output | 1 | Stored value holds a capture |

## Verification
The capture path is tried with a single rising pin on valid selects in two different ports. This separates the index arithmetic and shows the exact three-edge latency. It is also tried with every input toggling while a port code or pin number names nothing, which tells a working inhibit apart from a mux that wraps to a real pin. A second edge while the flag is set tells one-shot behaviour from simple overwrite. A newly selected pin that is already high tells a cleared detector history apart from a stale one. A clear timed onto an edge shows which of the two wins.

// File: rtl/tscap_pkg.sv
package tscap_pkg;
   localparam int TSC_PORT_FIELD_W = 3;
   localparam int TSC_PIN_FIELD_W  = 3;
   localparam int TSC_SEL_BYTE_W   = 8;

   typedef struct packed {
      logic [TSC_PORT_FIELD_W-1:0] port;
      logic [TSC_PIN_FIELD_W-1:0]  pin;
   } tsc_sel_t;
endpackage

// File: rtl/tscap_sync.sv
module tscap_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tscap_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q[0] <= '0;
            else        stage_q[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/tscap_pin_mux.sv
module tscap_pin_mux
   import tscap_pkg::*;
#(
   parameter int NUM_PORTS      = 4,
   parameter int PORT_W         = 8,
   parameter bit ZERO_PIN_VALID = 1'b0
) (
   input  logic [NUM_PORTS*PORT_W-1:0] pins,
   input  tsc_sel_t                    sel,
   output logic                        pin_val,
   output logic                        sel_ok
);
   localparam int TOTAL = NUM_PORTS * PORT_W;
   localparam int IDX_W = $clog2(TOTAL);

   if ($clog2(PORT_W) > TSC_PIN_FIELD_W) begin : g_bad_pin
      $error("tscap_pin_mux: PORT_W too wide for pin field");
   end
   if (NUM_PORTS > (1 << TSC_PORT_FIELD_W)) begin : g_bad_port
      $error("tscap_pin_mux: NUM_PORTS too large for port field");
   end

   logic port_ok, pin_ok;
   logic [IDX_W-1:0] idx;

   assign port_ok = int'(sel.port) < NUM_PORTS;

   if (ZERO_PIN_VALID) begin : g_pin_any
      assign pin_ok = int'(sel.pin) < PORT_W;
   end else begin : g_pin_nonzero
      assign pin_ok = (sel.pin != '0) && (int'(sel.pin) < PORT_W);
   end

   assign sel_ok = port_ok & pin_ok;
   assign idx    = IDX_W'(int'(sel.port) * PORT_W + int'(sel.pin));
   assign pin_val = sel_ok & pins[idx];

   // R3: a zero pin number never reaches the edge detector
   always_comb begin
      if (!ZERO_PIN_VALID && sel.pin == '0) begin
         p_pin_zero_quiet_r3: assert (!pin_val);
      end
   end
endmodule

// File: rtl/tscap_capture.sv
module tscap_capture #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_val,
   input  logic             sel_ok,
   input  logic             sel_wr,
   input  logic             clr,
   input  logic [CNT_W-1:0] count_in,
   output logic [CNT_W-1:0] cap_q,
   output logic             cap_valid
);
   logic prev_q, hist_ok_q, rise;

   assign rise = hist_ok_q & pin_val & ~prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q    <= 1'b0;
         hist_ok_q <= 1'b0;
         cap_valid <= 1'b0;
         cap_q     <= '0;
      end else begin
         prev_q    <= pin_val;
         hist_ok_q <= ~sel_wr;
         if (clr) begin
            cap_valid <= 1'b0;
         end else if (rise && sel_ok && !cap_valid) begin
            cap_valid <= 1'b1;
            cap_q     <= count_in;
         end
      end
   end

   p_rise_needs_pin_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_valid) |-> $past(pin_val));
   p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !cap_valid);
   p_hold_oneshot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_valid && !clr) |=> (cap_valid && $stable(cap_q)));
   p_inhibit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_ok && !cap_valid) |=> !cap_valid);
endmodule

// File: rtl/tscap_unit.sv
module tscap_unit
   import tscap_pkg::*;
#(
   parameter int NUM_PORTS      = 4,
   parameter int PORT_W         = 8,
   parameter int CNT_W          = 32,
   parameter int BYTE_W         = 8,
   parameter int SYNC_STAGES    = 2,
   parameter bit ZERO_PIN_VALID = 1'b0,
   localparam int NUM_BYTES     = CNT_W / BYTE_W,
   localparam int RD_W          = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_PORTS*PORT_W-1:0] gpio_in,
   input  logic [CNT_W-1:0]            count_in,
   input  logic                        sel_wr,
   input  logic [TSC_SEL_BYTE_W-1:0]   sel_wdata,
   input  logic                        clr_valid,
   input  logic [RD_W-1:0]             rd_idx,
   output logic [BYTE_W-1:0]           rd_byte,
   output logic                        capture_valid
);
   localparam int SEL_W = TSC_PORT_FIELD_W + TSC_PIN_FIELD_W;

   if (CNT_W % BYTE_W != 0) begin : g_bad_bytes
      $error("tscap_unit: CNT_W must be a multiple of BYTE_W");
   end

   tsc_sel_t                    sel_q;
   logic [NUM_PORTS*PORT_W-1:0] pins_sync;
   logic                        pin_val, sel_ok;
   logic [CNT_W-1:0]            cap_q;
   logic [BYTE_W-1:0]           byte_arr [NUM_BYTES];
   logic                        unused_sel_hi;

   assign unused_sel_hi = ^sel_wdata[TSC_SEL_BYTE_W-1:SEL_W];

   always_ff @(posedge clk) begin
      if (!rst_n)      sel_q <= '0;
      else if (sel_wr) sel_q <= tsc_sel_t'(sel_wdata[SEL_W-1:0]);
   end

   tscap_sync #(.W(NUM_PORTS*PORT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(gpio_in), .dout(pins_sync));

   tscap_pin_mux #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W),
                   .ZERO_PIN_VALID(ZERO_PIN_VALID)) u_mux (
      .pins(pins_sync), .sel(sel_q), .pin_val(pin_val), .sel_ok(sel_ok));

   tscap_capture #(.CNT_W(CNT_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .pin_val(pin_val), .sel_ok(sel_ok),
      .sel_wr(sel_wr), .clr(clr_valid), .count_in(count_in),
      .cap_q(cap_q), .cap_valid(capture_valid));

   for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
      assign byte_arr[b] = cap_q[b*BYTE_W +: BYTE_W];
   end

   assign rd_byte = (int'(rd_idx) < NUM_BYTES) ? byte_arr[rd_idx] : '0;

   p_sel_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sel_wr) && !capture_valid) |=> !capture_valid);
endmodule

// File: tb/tscap_unit_bench.sv
module tscap_unit_bench;
   localparam int SYNC = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] gpio_in = '0;
   logic [31:0] count_in = '0;
   logic        sel_wr = 1'b0;
   logic [7:0]  sel_wdata = '0;
   logic        clr_valid = 1'b0;
   logic [1:0]  rd_idx = '0;
   logic [7:0]  rd_byte;
   logic        capture_valid;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   tscap_unit u_tscap_unit (
      .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .count_in(count_in),
      .sel_wr(sel_wr), .sel_wdata(sel_wdata), .clr_valid(clr_valid),
      .rd_idx(rd_idx), .rd_byte(rd_byte), .capture_valid(capture_valid));

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
      end
   endtask

   // behavioural reference model, updated on every clock edge
   logic [31:0] gq[$];
   logic        m_valid, m_prev, m_hok;
   logic [31:0] m_cap;
   logic [5:0]  m_sel;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_valid = 0; m_prev = 0; m_hok = 0; m_cap = 0; m_sel = 0;
         gq.delete();
         for (int i = 0; i < SYNC; i++) gq.push_back(32'h0);
      end else begin
         int port, pin;
         logic ok, cur, edg;
         port = int'(m_sel[5:3]);
         pin  = int'(m_sel[2:0]);
         ok   = (port < 4) && (pin != 0);
         cur  = ok ? gq[0][port*8 + pin] : 1'b0;
         edg  = m_hok && cur && !m_prev;
         if (clr_valid) m_valid = 0;
         else if (edg && !m_valid) begin m_valid = 1; m_cap = count_in; end
         m_prev = cur;
         m_hok  = !sel_wr;
         if (sel_wr) m_sel = sel_wdata[5:0];
         void'(gq.pop_front());
         gq.push_back(gpio_in);
      end
   end

   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         check("R5 valid vs model", {31'b0, capture_valid}, {31'b0, m_valid});
         check("R7 byte vs model", {24'b0, rd_byte}, {24'b0, m_cap[int'(rd_idx)*8 +: 8]});
      end
   end

   initial begin : drive_free
      int c = 0;
      forever begin
         @(negedge clk);
         c++;
         count_in = c * 32'h0103_0507 + 32'h0A0B_0C0D;
         rd_idx   = rd_idx + 2'd1;
      end
   end

   task automatic wr_sel(logic [7:0] v);
      @(negedge clk); sel_wr = 1'b1; sel_wdata = v;
      @(negedge clk); sel_wr = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk); clr_valid = 1'b1;
      @(negedge clk); clr_valid = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // raise one pin and check the three-edge latency and stored bytes
   task automatic rise_and_check(int bitn, string req);
      logic [31:0] exp;
      @(negedge clk); gpio_in[bitn] = 1'b1;
      @(posedge clk); #2 check({req, " R4 no capture after edge 1"}, {31'b0, capture_valid}, 32'd0);
      @(posedge clk); #2 check({req, " R4 no capture after edge 2"}, {31'b0, capture_valid}, 32'd0);
      @(posedge clk); exp = count_in;
      #2 check({req, " R4 capture after edge 3"}, {31'b0, capture_valid}, 32'd1);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         check({req, " R7 byte lane"}, {24'b0, rd_byte}, {24'b0, exp[int'(rd_idx)*8 +: 8]});
      end
   endtask

   initial begin : main
      logic [31:0] held;
      idle(3);
      check("R9 reset valid", {31'b0, capture_valid}, 32'd0);
      check("R9 reset value", {24'b0, rd_byte}, 32'd0);
      @(negedge clk); rst_n = 1'b1;
      gpio_in = 32'hFFFF_FFFF;
      idle(6);
      check("R9 default select inhibits", {31'b0, capture_valid}, 32'd0);
      gpio_in = '0;
      idle(4);

      // R1: port C pin 5 is input bit 21
      wr_sel(8'h15);
      idle(3);
      rise_and_check(21, "R1");

      // R6: second edge while flag is set is ignored
      held = m_cap;
      @(negedge clk); gpio_in[21] = 1'b0;
      idle(4);
      gpio_in[21] = 1'b1;
      idle(6);
      check("R6 flag held", {31'b0, capture_valid}, 32'd1);
      check("R6 value held", m_cap, held);

      // R5: clear, pin already high so no new capture
      pulse_clr();
      check("R5 cleared", {31'b0, capture_valid}, 32'd0);
      idle(5);
      check("R5 no capture on level", {31'b0, capture_valid}, 32'd0);

      // R5: clear coinciding with the capture edge wins
      @(negedge clk); gpio_in[21] = 1'b0;
      idle(4);
      gpio_in[21] = 1'b1;
      @(negedge clk);
      @(negedge clk); clr_valid = 1'b1;
      @(negedge clk); clr_valid = 1'b0;
      idle(4);
      check("R5 clear beats edge", {31'b0, capture_valid}, 32'd0);

      // R2: port code 5 inhibits whatever toggles
      wr_sel(8'h2D);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk); gpio_in = '0;
         idle(3);
         gpio_in = 32'hFFFF_FFFF;
         idle(3);
      end
      check("R2 invalid port", {31'b0, capture_valid}, 32'd0);

      // R3: pin 0 of port C inhibits
      @(negedge clk); gpio_in = '0;
      wr_sel(8'h10);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); gpio_in = '0;
         idle(3);
         gpio_in = 32'hFFFF_FFFF;
         idle(3);
      end
      check("R3 pin zero", {31'b0, capture_valid}, 32'd0);

      // R1: port D pin 7 is input bit 31; other pins do nothing
      @(negedge clk); gpio_in = '0;
      wr_sel(8'h1F);
      idle(3);
      gpio_in = 32'h7FFF_FFFF;
      idle(5);
      check("R1 other pins ignored", {31'b0, capture_valid}, 32'd0);
      rise_and_check(31, "R1");
      pulse_clr();

      // R8: newly selected pin already high is no edge
      wr_sel(8'h38);
      @(negedge clk); gpio_in = 32'hFFFF_FFFF;
      idle(4);
      wr_sel(8'hCB);
      idle(6);
      check("R8 no edge on select change", {31'b0, capture_valid}, 32'd0);
      @(negedge clk); gpio_in[11] = 1'b0;
      idle(4);
      rise_and_check(11, "R8");

      idle(4);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule